// File: doc/BRIEF.md
# Software-Steered Lockable Translation Buffer

This block is a small, fully associative address translation buffer for a coprocessor memory unit. Software manages it entirely through a word-addressed register port. A staging pair holds the virtual tag, page size, valid and preserved flags, and the physical page base of a new entry. A lock register splits the entries into two parts: a protected region below a base index, and a replaceable region above it. The victim index in the same lock register chooses which entry a load writes, which entry a single flush invalidates, and which entry the two view registers show.

Translation happens in the same cycle. The input virtual address is compared against every valid entry. Each entry masks the compare by its own page size (4 KB, 64 KB or 1 MB). The lowest-indexed matching entry supplies the physical page, and the untranslated low bits are passed through. A control register turns translation on and off. A soft-reset register clears the table and runs a short busy interval, which a status bit reports. A revision register identifies the block.

Top module: `locked_tlb`

## Requirements
- R1: After the synchronous active-low reset, every entry is invalid, the lock register and control register read 0, status (address 2) bit 0 reads 1, and the revision register (address 0) reads major version in bits [7:4] and minor version in bits [3:0] (defaults 1 and 2, so 0x12).
- R2: The lock register (address 4) holds the base index in bits [12:10] and the victim index in bits [6:4] (3 bits each for 8 entries), and it reads back as written.
- R3: Writing a value with bit 0 set to the load command (address 5) copies the staged entry into the entry chosen by the victim index. The staged entry comes from the tag staging word (address 8: tag in [31:12], size in [3:2], preserved in [1], valid in [0]) and the physical staging word (address 9: page base in [31:12]).
- R4: A load is ignored, and the entry is left unchanged, when the victim index is the last entry (N-1) or when the victim lies below the base and that entry is already valid.
- R5: The entry view registers show the entry at the victim index. Address 10 shows the tag word in the staging layout, and address 11 shows the physical page in [31:12] with zeros below.
- R6: Writing bit 0 set to the single-flush command (address 6) clears the valid and preserved flags of the victim entry. Its tag and page stay visible in the view registers.
- R7: Writing bit 0 set to the global-flush command (address 7) invalidates every entry that is not marked preserved. Preserved entries keep translating.
- R8: Size code 0 selects 4 KB pages (12 offset bits pass through), code 1 selects 64 KB pages (16 bits), code 2 selects 1 MB pages (20 bits), and code 3 behaves as 4 KB.
- R9: In the same cycle as the address is applied, the lookup raises the hit output and produces the translated address whenever some valid entry matches. When several entries match, the lowest index wins. On a miss the hit output is low and the output address equals the input.
- R10: Writing the control register (address 3) with bit 1 set enables translation. Writing it with bit 1 clear disables translation and clears all entries and the lock register. While disabled, the hit output is low and the output address equals the input. The control register reads the enable in bit 1.
- R11: Writing exactly 0x2 to the soft-reset register (address 1) clears all entries, the lock register and the enable. Status bit 0 then reads 0 for RST_CYC (default 4) cycles, and all register writes in that interval are ignored. Any other value written to address 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data for reg_addr (combinational) |
| lk_va | input | AW | Virtual address to translate |
| lk_hit | output | 1 | A valid entry matched lk_va |
| lk_pa | output | AW | Translated address, or lk_va on a miss or while disabled |

## Verification
The hardest states to reach are the ones where the lock rules decide whether a load lands. These are a victim below the base that points at a valid entry and must be refused, and a victim below the base that points at a flushed entry and must be accepted. The stimulus reaches them by first building a table with two deliberately overlapping 4 KB entries. It flushes the lower one so that translation falls over to the higher index, then raises the base above both before retrying loads at each victim. A preserved entry is loaded before the global flush so that the flush has both survivors and casualties. A behavioural model in the bench follows every register write and compares the lookup result and the read data on every clock.

// File: rtl/lktlb_pkg.sv
// Shared encodings for the lockable translation buffer.
// Assumes 4 KB minimum pages, so the low 12 address bits never translate.
package lktlb_pkg;

    localparam int PG_SHIFT      = 12;
    localparam int LOCK_VIC_LSB  = 4;
    localparam int LOCK_BASE_LSB = 10;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_RSV = 2'd3
    } pg_size_e;

    typedef enum logic [3:0] {
        RA_REV      = 4'd0,
        RA_SYSCFG   = 4'd1,
        RA_SYSSTAT  = 4'd2,
        RA_CTRL     = 4'd3,
        RA_LOCK     = 4'd4,
        RA_LOAD     = 4'd5,
        RA_FLUSH1   = 4'd6,
        RA_FLUSHALL = 4'd7,
        RA_CAM_STG  = 4'd8,
        RA_RAM_STG  = 4'd9,
        RA_CAM_VIEW = 4'd10,
        RA_RAM_VIEW = 4'd11
    } reg_addr_e;

    // Mask of page-number bits that bypass translation for a size code.
    function automatic logic [7:0] bypass_mask(input logic [1:0] sz);
        case (sz)
            PG_64K:  return 8'h0F;
            PG_1M:   return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/lktlb_store.sv
// Entry storage: tag, size, flags and physical page per slot.
// Applies load, single flush, global flush and full clear.
// Assumes at most one command per cycle (they come from distinct addresses).
module lktlb_store #(
    parameter int N     = 8,
    parameter int TAG_W = 20,
    parameter int IW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             flush_all,
    input  logic             flush_one,
    input  logic             load,
    input  logic [IW-1:0]    vic,
    input  logic [IW-1:0]    base,
    input  logic [TAG_W-1:0] stg_tag,
    input  logic [1:0]       stg_size,
    input  logic             stg_pres,
    input  logic             stg_valid,
    input  logic [TAG_W-1:0] stg_ppn,
    output logic [N-1:0]     valid_q,
    output logic [N-1:0]     pres_q,
    output logic [1:0]       size_q [N],
    output logic [TAG_W-1:0] tag_q  [N],
    output logic [TAG_W-1:0] ppn_q  [N]
);

    for (genvar g = 0; g < N; g++) begin : g_ent
        localparam bit SLOT_OK = (g != N - 1);
        logic             v_r, p_r, load_here;
        logic [1:0]       s_r;
        logic [TAG_W-1:0] t_r, a_r;

        // Load is refused on the last slot and on a valid locked slot.
        assign load_here = load && (vic == IW'(g)) && SLOT_OK
                           && !((IW'(g) < base) && v_r);

        // Per-slot state update, clear has priority over commands.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                v_r <= 1'b0;
                p_r <= 1'b0;
                s_r <= '0;
                t_r <= '0;
                a_r <= '0;
            end else if (flush_all) begin
                v_r <= v_r & p_r;
            end else if (flush_one && (vic == IW'(g))) begin
                v_r <= 1'b0;
                p_r <= 1'b0;
            end else if (load_here) begin
                v_r <= stg_valid;
                p_r <= stg_pres;
                s_r <= stg_size;
                t_r <= stg_tag;
                a_r <= stg_ppn;
            end
        end

        assign valid_q[g] = v_r;
        assign pres_q[g]  = p_r;
        assign size_q[g]  = s_r;
        assign tag_q[g]   = t_r;
        assign ppn_q[g]   = a_r;
    end

    // R6
    flush_one_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_one |=> !valid_q[$past(vic)]);

    // R7
    gflush_keep_pres_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> ((valid_q & ~$past(valid_q & pres_q)) == '0));

    // R4
    last_slot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q[N-1]);

endmodule

// File: rtl/lktlb_lookup.sv
// Single-cycle associative lookup with per-entry page-size masking.
// The lowest matching index wins; a miss or disabled state passes va through.
module lktlb_lookup #(
    parameter int N     = 8,
    parameter int TAG_W = 20,
    parameter int IW    = 3,
    parameter int AW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [AW-1:0]    va,
    input  logic [N-1:0]     valid_q,
    input  logic [1:0]       size_q [N],
    input  logic [TAG_W-1:0] tag_q  [N],
    input  logic [TAG_W-1:0] ppn_q  [N],
    output logic             hit,
    output logic [AW-1:0]    pa
);
    import lktlb_pkg::*;

    logic [TAG_W-1:0] va_tag, keep_sel, pa_tag;
    logic [TAG_W-1:0] keep [N];
    logic [N-1:0]     match;
    logic [IW-1:0]    sel;
    logic             found;

    assign va_tag = va[AW-1:PG_SHIFT];

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign keep[g]  = ~TAG_W'(bypass_mask(size_q[g]));
        assign match[g] = valid_q[g] && (((va_tag ^ tag_q[g]) & keep[g]) == '0);
    end

    // Priority pick: scanning downward leaves the lowest match selected.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel   = IW'(i);
                found = 1'b1;
            end
        end
    end

    // Merge kept physical bits with bypassed virtual bits.
    always_comb begin
        keep_sel = keep[sel];
        pa_tag   = (ppn_q[sel] & keep_sel) | (va_tag & ~keep_sel);
        hit      = en && found;
        pa       = hit ? {pa_tag, va[PG_SHIFT-1:0]} : va;
    end

    // R10
    off_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!hit && (pa == va)));

    // R9
    hit_has_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (valid_q != '0));

endmodule

// File: rtl/locked_tlb.sv
// Top: register port, lock register, staging, control and soft reset.
// Assumes N is a power of two so the lock fields index every slot.
// Register reads are combinational on reg_addr.
module locked_tlb #(
    parameter int N       = 8,
    parameter int AW      = 32,
    parameter int RST_CYC = 4,
    parameter int REV_MAJ = 1,
    parameter int REV_MIN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [3:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic [AW-1:0] lk_va,
    output logic          lk_hit,
    output logic [AW-1:0] lk_pa
);
    import lktlb_pkg::*;

    localparam int LW    = $clog2(N);
    localparam int TAG_W = AW - PG_SHIFT;
    localparam int CW    = $clog2(RST_CYC + 1);

    logic          en_q;
    logic [LW-1:0] base_q, vic_q;
    logic [CW-1:0] rcnt_q;
    logic [AW-1:0] stg_cam_q;
    logic [TAG_W-1:0] stg_ppn_q;

    logic wr_ok, srst_go, ctrl_off, clr_all;
    logic cmd_load, cmd_fl1, cmd_flall;

    logic [N-1:0]     valid_q, pres_q;
    logic [1:0]       size_q [N];
    logic [TAG_W-1:0] tag_q  [N];
    logic [TAG_W-1:0] ppn_q  [N];

    assign wr_ok     = reg_wr && (rcnt_q == '0);
    assign srst_go   = wr_ok && (reg_addr == RA_SYSCFG) && (reg_wdata == AW'(2));
    assign ctrl_off  = wr_ok && (reg_addr == RA_CTRL) && !reg_wdata[1];
    assign clr_all   = srst_go || ctrl_off;
    assign cmd_load  = wr_ok && (reg_addr == RA_LOAD) && reg_wdata[0];
    assign cmd_fl1   = wr_ok && (reg_addr == RA_FLUSH1) && reg_wdata[0];
    assign cmd_flall = wr_ok && (reg_addr == RA_FLUSHALL) && reg_wdata[0];

    // Soft-reset busy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)              rcnt_q <= '0;
        else if (srst_go)        rcnt_q <= CW'(RST_CYC);
        else if (rcnt_q != '0)   rcnt_q <= rcnt_q - 1'b1;
    end

    // Enable flag and lock fields.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            en_q   <= 1'b0;
            base_q <= '0;
            vic_q  <= '0;
        end else if (wr_ok && (reg_addr == RA_CTRL)) begin
            en_q <= 1'b1;
        end else if (wr_ok && (reg_addr == RA_LOCK)) begin
            base_q <= reg_wdata[LOCK_BASE_LSB +: LW];
            vic_q  <= reg_wdata[LOCK_VIC_LSB +: LW];
        end
    end

    // Staging words for the next load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_cam_q <= '0;
            stg_ppn_q <= '0;
        end else if (wr_ok && (reg_addr == RA_CAM_STG)) begin
            stg_cam_q <= reg_wdata;
        end else if (wr_ok && (reg_addr == RA_RAM_STG)) begin
            stg_ppn_q <= reg_wdata[AW-1:PG_SHIFT];
        end
    end

    lktlb_store #(.N(N), .TAG_W(TAG_W), .IW(LW)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (clr_all),
        .flush_all (cmd_flall),
        .flush_one (cmd_fl1),
        .load      (cmd_load),
        .vic       (vic_q),
        .base      (base_q),
        .stg_tag   (stg_cam_q[AW-1:PG_SHIFT]),
        .stg_size  (stg_cam_q[3:2]),
        .stg_pres  (stg_cam_q[1]),
        .stg_valid (stg_cam_q[0]),
        .stg_ppn   (stg_ppn_q),
        .valid_q   (valid_q),
        .pres_q    (pres_q),
        .size_q    (size_q),
        .tag_q     (tag_q),
        .ppn_q     (ppn_q)
    );

    lktlb_lookup #(.N(N), .TAG_W(TAG_W), .IW(LW), .AW(AW)) i_lookup (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .va      (lk_va),
        .valid_q (valid_q),
        .size_q  (size_q),
        .tag_q   (tag_q),
        .ppn_q   (ppn_q),
        .hit     (lk_hit),
        .pa      (lk_pa)
    );

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_REV:      reg_rdata = AW'({4'(REV_MAJ), 4'(REV_MIN)});
            RA_SYSSTAT:  reg_rdata = AW'(rcnt_q == '0);
            RA_CTRL:     reg_rdata = AW'({en_q, 1'b0});
            RA_LOCK:     reg_rdata = (AW'(base_q) << LOCK_BASE_LSB)
                                   | (AW'(vic_q) << LOCK_VIC_LSB);
            RA_CAM_STG:  reg_rdata = stg_cam_q;
            RA_RAM_STG:  reg_rdata = {stg_ppn_q, {PG_SHIFT{1'b0}}};
            RA_CAM_VIEW: reg_rdata = {tag_q[vic_q], {(PG_SHIFT-4){1'b0}},
                                      size_q[vic_q], pres_q[vic_q], valid_q[vic_q]};
            RA_RAM_VIEW: reg_rdata = {ppn_q[vic_q], {PG_SHIFT{1'b0}}};
            default:     reg_rdata = '0;
        endcase
    end

    // R11
    srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_go |=> ((valid_q == '0) && (reg_addr != RA_SYSSTAT || reg_rdata == '0)));

    // R10
    ctrl_off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_off |=> ((valid_q == '0) && !lk_hit));

endmodule

// File: tb/test_locked_tlb.sv
module test_locked_tlb;

    localparam int N = 8;
    localparam int RST_CYC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [31:0] lk_va = 32'd0;
    logic        lk_hit;
    logic [31:0] lk_pa;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    locked_tlb #(.N(N), .AW(32), .RST_CYC(RST_CYC)) i_locked_tlb (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa)
    );

    // ---------------- behavioural reference model ----------------
    bit          m_v [N];
    bit          m_p [N];
    int          m_sz [N];
    logic [19:0] m_tag [N];
    logic [19:0] m_ppn [N];
    int          m_base, m_vic, m_rc;
    bit          m_en;
    logic [31:0] m_stcam, m_stram;

    function automatic void m_clear();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_p[i] = 0; m_sz[i] = 0; m_tag[i] = '0; m_ppn[i] = '0;
        end
        m_base = 0; m_vic = 0; m_en = 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_clear();
            m_rc = 0; m_stcam = '0; m_stram = '0;
        end else if (m_rc > 0) begin
            m_rc--;
        end else if (reg_wr) begin
            case (reg_addr)
                4'd1: if (reg_wdata == 32'h2) begin m_clear(); m_rc = RST_CYC; end
                4'd3: if (reg_wdata[1]) m_en = 1; else m_clear();
                4'd4: begin m_base = int'(reg_wdata[12:10]); m_vic = int'(reg_wdata[6:4]); end
                4'd5: if (reg_wdata[0] && m_vic != N-1 && !(m_vic < m_base && m_v[m_vic])) begin
                          m_v[m_vic] = m_stcam[0]; m_p[m_vic] = m_stcam[1];
                          m_sz[m_vic] = int'(m_stcam[3:2]);
                          m_tag[m_vic] = m_stcam[31:12]; m_ppn[m_vic] = m_stram[31:12];
                      end
                4'd6: if (reg_wdata[0]) begin m_v[m_vic] = 0; m_p[m_vic] = 0; end
                4'd7: if (reg_wdata[0]) for (int i = 0; i < N; i++) m_v[i] = m_v[i] & m_p[i];
                4'd8: m_stcam = reg_wdata;
                4'd9: m_stram = reg_wdata & 32'hFFFF_F000;
                default: ;
            endcase
        end
    end

    function automatic void m_look(input logic [31:0] va, output bit h, output logic [31:0] pa);
        h = 0; pa = va;
        if (!m_en) return;
        for (int i = 0; i < N; i++) begin
            int s;
            s = (m_sz[i] == 1) ? 4 : ((m_sz[i] == 2) ? 8 : 0);
            if (m_v[i] && ((va >> (12 + s)) == (32'(m_tag[i]) >> s))) begin
                h = 1;
                pa = ((32'(m_ppn[i]) >> s) << (12 + s)) | (va & ((32'h1 << (12 + s)) - 1));
                return;
            end
        end
    endfunction

    function automatic logic [31:0] m_rd(input logic [3:0] a);
        case (a)
            4'd0:  return 32'h12;
            4'd2:  return (m_rc == 0) ? 32'h1 : 32'h0;
            4'd3:  return m_en ? 32'h2 : 32'h0;
            4'd4:  return (32'(m_base) << 10) | (32'(m_vic) << 4);
            4'd8:  return m_stcam;
            4'd9:  return m_stram;
            4'd10: return {m_tag[m_vic], 8'h0, 2'(m_sz[m_vic]), m_p[m_vic], m_v[m_vic]};
            4'd11: return {m_ppn[m_vic], 12'h0};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit h; logic [31:0] pa;
            m_look(lk_va, h, pa);
            chk("R9 model hit", 32'(lk_hit), 32'(h));
            chk("R9 model pa", lk_pa, pa);
            chk("R5 model rdata", reg_rdata, m_rd(reg_addr));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        @(negedge clk);
        chk(req, reg_rdata, exp);
        @(posedge clk); #1;
    endtask

    task automatic lk(input logic [31:0] va, input bit eh, input logic [31:0] ep, input string req);
        lk_va = va;
        @(negedge clk);
        chk(req, 32'(lk_hit), 32'(eh));
        chk(req, lk_pa, ep);
        @(posedge clk); #1;
    endtask

    task automatic put(input logic [31:0] lock, input logic [31:0] cam, input logic [31:0] ram);
        wr(4'd4, lock); wr(4'd8, cam); wr(4'd9, ram); wr(4'd5, 32'h1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(4'd0, 32'h12, "R1 revision");
        rd(4'd2, 32'h1, "R1 status idle");
        rd(4'd4, 32'h0, "R1 lock cleared");
        lk(32'h0001_0ABC, 0, 32'h0001_0ABC, "R1 no hit after reset");
        wr(4'd3, 32'h2);
        rd(4'd3, 32'h2, "R10 enabled");
        // R3 4 KB load at victim 0
        put(32'h0, 32'h0001_0001, 32'h8000_0000);
        lk(32'h0001_0ABC, 1, 32'h8000_0ABC, "R3 load then hit");
        lk(32'h0001_1ABC, 0, 32'h0001_1ABC, "R8 4KB neighbour misses");
        // R8 64 KB at victim 1, 1 MB at victim 2
        put(32'h10, 32'h0020_0005, 32'h9000_0000);
        lk(32'h0020_5123, 1, 32'h9000_5123, "R8 64KB bypass");
        put(32'h20, 32'h3000_0009, 32'hA000_0000);
        lk(32'h3001_2345, 1, 32'hA001_2345, "R8 1MB bypass");
        rd(4'd10, 32'h3000_0009, "R5 tag view");
        rd(4'd11, 32'hA000_0000, "R5 page view");
        // R9 overlap at victim 3, lowest index wins
        put(32'h30, 32'h0001_0001, 32'hB000_0000);
        lk(32'h0001_0ABC, 1, 32'h8000_0ABC, "R9 lowest index wins");
        // R6 flush entry 0
        wr(4'd4, 32'h0);
        wr(4'd6, 32'h1);
        lk(32'h0001_0ABC, 1, 32'hB000_0ABC, "R6 flush falls to next");
        rd(4'd10, 32'h0001_0000, "R6 tag kept flags cleared");
        // R2/R4 lock protection
        wr(4'd4, 32'hC10);
        rd(4'd4, 32'hC10, "R2 lock readback");
        wr(4'd8, 32'h5550_0001); wr(4'd9, 32'hC000_0000); wr(4'd5, 32'h1);
        rd(4'd10, 32'h0020_0005, "R4 locked valid kept");
        lk(32'h5550_0000, 0, 32'h5550_0000, "R4 refused load misses");
        wr(4'd4, 32'hC00);
        wr(4'd5, 32'h1);
        lk(32'h5550_0123, 1, 32'hC000_0123, "R4 locked invalid accepts");
        wr(4'd4, 32'h70);
        wr(4'd5, 32'h1);
        rd(4'd10, 32'h0, "R4 last slot refused");
        // R7 preserved survives global flush
        put(32'h40, 32'h6660_0003, 32'hD000_0000);
        wr(4'd7, 32'h1);
        lk(32'h6660_0777, 1, 32'hD000_0777, "R7 preserved kept");
        lk(32'h3001_2345, 0, 32'h3001_2345, "R7 plain entry gone");
        lk(32'h5550_0123, 0, 32'h5550_0123, "R7 plain entry gone");
        // R10 disable clears
        wr(4'd3, 32'h0);
        lk(32'h6660_0777, 0, 32'h6660_0777, "R10 disabled passthru");
        wr(4'd3, 32'h2);
        lk(32'h6660_0777, 0, 32'h6660_0777, "R10 entries cleared");
        rd(4'd4, 32'h0, "R10 lock cleared");
        // R11 soft reset
        put(32'h50, 32'h1230_0001, 32'hE000_0000);
        lk(32'h1230_0000, 1, 32'hE000_0000, "R11 before soft reset");
        wr(4'd1, 32'h2);
        rd(4'd2, 32'h0, "R11 busy");
        wr(4'd4, 32'h50);
        rd(4'd4, 32'h0, "R11 write ignored while busy");
        repeat (5) begin @(posedge clk); #1; end
        rd(4'd2, 32'h1, "R11 done");
        rd(4'd3, 32'h0, "R11 enable cleared");
        wr(4'd3, 32'h2);
        lk(32'h1230_0000, 0, 32'h1230_0000, "R11 entries cleared");
        wr(4'd1, 32'h1);
        rd(4'd2, 32'h1, "R11 other value ignored");
        rd(4'd3, 32'h2, "R11 other value ignored");
        finish_run();
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

endmodule